// File: doc/BRIEF.md
# Low-Activity Sequential Shift-Add Multiplier

This block multiplies two unsigned W-bit operands into a 2W-bit product. It examines one bit of the multiplier per clock, so an operation needs W clock cycles. It is built to keep switching activity low:

- Both operand registers are loaded once and never move.
- A one-hot token, walking one position per clock, selects the multiplier bit to examine. No binary count is decoded.
- The multiplicand goes to the adder without per-bit gating.
- The accumulator is never shifted. Each addition is aimed at the slice of the product that lines up with the current bit.
- When the selected bit is zero, the adder result is discarded and the product register is not written.

A client pulses `start` with the operands on `a_in` and `b_in`. It then waits for the one-cycle `done` pulse, after which `product` holds the result until the next accepted start. The sequencer has three named states:

- `S_IDLE` waits for a start pulse. Transition: `S_IDLE` to `S_RUN` on a start pulse.
- `S_RUN` lasts while the token walks across the multiplier. Transition: `S_RUN` to `S_DONE` when the token sits on the top position.
- `S_DONE` lasts one cycle and raises `done`. Transition: `S_DONE` to `S_IDLE` unconditionally.

Top module: `lowact_mult`

## Requirements
- R1: A start pulse sampled in `S_IDLE` clears `product` to zero, captures `a_in` and `b_in`, and raises `busy` from the next cycle on.
- R2: `done` is high for exactly one cycle. It is seen W cycles after the clock edge that accepted start, whatever the operand values. `busy` drops one cycle later.
- R3: When `done` is high, `product` equals the unsigned product of the captured operands. The value then stays unchanged until the next accepted start.
- R4: `add_we` is high only in `S_RUN` cycles whose selected multiplier bit is 1. Over one operation it is high exactly popcount(B) times. `product` never changes on a cycle where `add_we` was low, apart from the clear at start.
- R5: A start pulse that arrives while `busy` is high is ignored: the running operation's result and timing are unchanged.
- R6: A zero operand gives a zero product. With B equal to zero, `add_we` never rises.
- R7: All-ones times all-ones gives (2^W-1)^2, with the carry reaching bit 2W-1.
- R8: The bit-select token is one-hot during `S_RUN` and all-zero whenever `busy` is low. It is removed, not wrapped, after the top position.
- R9: After reset, `busy`, `done`, `add_we` and `product` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; honoured only when idle |
| a_in | input | W | Multiplicand |
| b_in | input | W | Multiplier |
| busy | output | 1 | Operation in progress (`S_RUN` or `S_DONE`) |
| done | output | 1 | One-cycle result-ready pulse |
| add_we | output | 1 | Product register is written by an add on the next edge |
| product | output | 2W | Unsigned product |

## Verification
The hardest situation to reach from the ports is a start pulse landing in the middle of a run. The bench fires a second start with different operands several cycles into an operation. It then checks that the original result still arrives on schedule. The carry into the top product bit also needs special stimulus, which all-ones and top-bit-only operands provide. The skipping of zero bits is confirmed by counting `add_we` cycles against the popcount of B, for sparse, dense and random multipliers.

// File: rtl/lowact_mult_pkg.sv
package lowact_mult_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } mstate_t;
endpackage

// File: rtl/lowact_ring.sv
// One-hot bit-select token: loaded at bit 0, walks upward, falls off the top.
module lowact_ring #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] tok
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tok <= '0;
        end else if (load) begin
            tok <= {{(W-1){1'b0}}, 1'b1};
        end else if (step) begin
            tok <= {tok[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/lowact_addalign.sv
// Picks the product window under the token, adds A, and merges the sum back.
module lowact_addalign #(
    parameter int W = 32
) (
    input  logic [W-1:0]   tok,
    input  logic [W-1:0]   a_q,
    input  logic [W-1:0]   b_q,
    input  logic [2*W-1:0] prod_q,
    output logic           hit,
    output logic [2*W-1:0] prod_nxt
);
    localparam int PW = 2 * W;

    logic [W-1:0] win;
    logic [W:0]   sum;

    assign hit = |(tok & b_q);

    always_comb begin
        win = '0;
        for (int k = 0; k < W; k++) begin
            if (tok[k]) win = win | prod_q[k +: W];
        end
    end

    assign sum = {1'b0, win} + {1'b0, a_q};

    always_comb begin
        prod_nxt = prod_q;
        for (int k = 0; k < W; k++) begin
            if (tok[k]) prod_nxt[k +: (W + 1)] = sum;
        end
    end

    logic unused_w;
    assign unused_w = ^PW;
endmodule

// File: rtl/lowact_mult.sv
module lowact_mult
    import lowact_mult_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    output logic           busy,
    output logic           done,
    output logic           add_we,
    output logic [2*W-1:0] product
);
    mstate_t        st_q, st_d;
    logic [W-1:0]   a_q, b_q, tok;
    logic [2*W-1:0] prod_nxt;
    logic           accept, hit, running;

    assign accept  = (st_q == S_IDLE) && start;
    assign running = (st_q == S_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (start) st_d = S_RUN;
            S_RUN:   if (tok[W-1]) st_d = S_DONE;
            S_DONE:  st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy   = (st_q != S_IDLE);
        done   = (st_q == S_DONE);
        add_we = running && hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (accept) begin
            a_q <= a_in;
            b_q <= b_in;
        end
    end

    lowact_ring #(.W(W)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (running),
        .tok   (tok)
    );

    lowact_addalign #(.W(W)) u_add (
        .tok      (tok),
        .a_q      (a_q),
        .b_q      (b_q),
        .prod_q   (product),
        .hit      (hit),
        .prod_nxt (prod_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      product <= '0;
        else if (accept) product <= '0;
        else if (add_we) product <= prod_nxt;
    end
endmodule

// File: rtl/lowact_mult_chk.sv
module lowact_mult_chk #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic           add_we,
    input logic [2*W-1:0] product,
    input logic [W-1:0]   a_q,
    input logic [W-1:0]   b_q,
    input logic [W-1:0]   tok
);
    logic [2*W-1:0] ref_p;
    assign ref_p = {{W{1'b0}}, a_q} * {{W{1'b0}}, b_q};

    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && product == '0));
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    p_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (product == ref_p));
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));
    p_skip_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !add_we) |=> $stable(product));
    p_we_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        add_we |-> busy);
    p_tok_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tok));
    p_tok_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tok == '0));
endmodule

bind lowact_mult lowact_mult_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .add_we  (add_we),
    .product (product),
    .a_q     (a_q),
    .b_q     (b_q),
    .tok     (tok)
);

// File: tb/lowact_mult_tb.sv
module lowact_mult_tb;
    localparam int W  = 32;
    localparam int NV = 8;

    localparam logic [W-1:0] VA [NV] = '{
        32'h0000_0000, 32'h1234_5678, 32'h0000_0001, 32'h0000_0003,
        32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_FFFF, 32'h0001_0000};
    localparam logic [W-1:0] VB [NV] = '{
        32'hDEAD_BEEF, 32'h0000_0000, 32'h0000_0001, 32'h0000_0005,
        32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_FFFF, 32'h0001_0000};
    localparam logic [2*W-1:0] VP [NV] = '{
        64'h0, 64'h0, 64'h1, 64'hF,
        64'hFFFF_FFFE_0000_0001, 64'h4000_0000_0000_0000,
        64'h0000_0000_FFFE_0001, 64'h0000_0001_0000_0000};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [W-1:0]   a_in = '0, b_in = '0;
    logic           busy, done, add_we;
    logic [2*W-1:0] product;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    lowact_mult #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
        .busy(busy), .done(done), .add_we(add_we), .product(product));

    task automatic check(input string req, input logic [2*W-1:0] act,
                         input logic [2*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Runs one operation; optionally pulses a stray start after 'poke' cycles.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input int poke,
                          output logic [2*W-1:0] p, output int cyc,
                          output int wr);
        @(negedge clk);
        a_in = a; b_in = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; wr = 0;
        while (!done && cyc < 1000) begin
            if (add_we) wr++;
            if (cyc == poke) begin
                a_in = ~a; b_in = ~b; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        p = product;
    endtask

    function automatic int popc(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(v[i]);
        return n;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [2*W-1:0] p;
        int cyc, wr;

        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 busy", 64'(busy), 64'd0);
        check("R9 done", 64'(done), 64'd0);
        check("R9 add_we", 64'(add_we), 64'd0);
        check("R9 product", product, 64'd0);
        rst_n = 1'b1;

        // vector table: R3 result, R2 timing, R4 write count, R6/R7 corners
        for (int v = 0; v < NV; v++) begin
            run_op(VA[v], VB[v], -1, p, cyc, wr);
            check("R3 table product", p, VP[v]);
            check("R2 table latency", 64'(cyc), 64'(W));
            check("R4 table writes", 64'(wr), 64'(popc(VB[v])));
        end

        // R6: zero multiplier writes nothing, zero result
        run_op(32'hCAFE_F00D, 32'h0, -1, p, cyc, wr);
        check("R6 zero B product", p, 64'd0);
        check("R6 zero B writes", 64'(wr), 64'd0);
        run_op(32'h0, 32'hFFFF_FFFF, -1, p, cyc, wr);
        check("R6 zero A product", p, 64'd0);

        // R7: all ones, top carry bit set
        run_op('1, '1, -1, p, cyc, wr);
        check("R7 all ones", p, 64'hFFFF_FFFE_0000_0001);

        // R2: done lasts one cycle and busy drops after; R3 holds result
        @(negedge clk);
        check("R2 done one cycle", 64'(done), 64'd0);
        check("R2 busy dropped", 64'(busy), 64'd0);
        repeat (4) @(negedge clk);
        check("R3 result held", product, 64'hFFFF_FFFE_0000_0001);

        // R5: stray start mid-run ignored
        run_op(32'h0000_1234, 32'h0000_0100, 5, p, cyc, wr);
        check("R5 product unchanged", p, 64'h0012_3400);
        check("R5 latency unchanged", 64'(cyc), 64'(W));
        check("R5 writes unchanged", 64'(wr), 64'd1);

        // R1: new start clears product before any add
        @(negedge clk);
        a_in = 32'h5; b_in = 32'h2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R1 cleared", product, 64'd0);
        check("R1 busy", 64'(busy), 64'd1);
        while (!done) @(negedge clk);
        check("R1 operands captured", product, 64'hA);

        // random operands, reference multiply
        for (int r = 0; r < 24; r++) begin
            logic [W-1:0] ra, rb;
            ra = $urandom();
            rb = (r % 3 == 0) ? ($urandom() & $urandom()) : $urandom();
            run_op(ra, rb, -1, p, cyc, wr);
            check("R3 random product", p, {32'd0, ra} * {32'd0, rb});
            check("R4 random writes", 64'(wr), 64'(popc(rb)));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule